// File: doc/BRIEF.md
# Segmented Logical-to-Physical Address Translator

This unit turns a 16-bit logical address into a 20-bit physical address. The logical space is cut into 4 KB pages. The top two pages always form an extended-code window. Below that window, one configuration byte holds two page numbers. They split the remaining pages into a stack region, a data region and a root region. Either of the two lower regions may shrink to nothing. Each region owns an 8-bit frame base. The physical address is that base plus the logical page number, joined to the untouched 12-bit page offset, and the sum wraps within 20 bits.

The unit can separate instruction space from data space. When the caller flags an access as data, physical bit 16 and/or bit 19 can be flipped, chosen separately for the root region and the data region. The flip is applied to the address the unit hands out, so any later 256 KB quadrant decode sees the flipped bits. Instruction fetches are never altered.

Configuration goes through a small address/data/strobe port that also reads back. The translated address is registered and appears one clock after the logical address is presented.

Top module: `amx_top`

## Requirements
- R1: While `rst` is high, every configuration register, `phys_addr` and `cfg_rdata` are cleared to zero. With all-zero configuration every page below 0xE lands in the stack region at base 0, so `phys_addr` equals the logical address zero-extended.
- R2: Logical pages 0xE and 0xF belong to the extended-code region. For these pages `phys_addr[19:12]` = (extended-code base + page) mod 256.
- R3: With H = `cfg_size[7:4]`, a page p with H <= p < 0xE belongs to the stack region and uses the stack base. If H >= 0xE the stack region is empty. If H = 0, every page below 0xE is stack.
- R4: With L = `cfg_size[3:0]`, a page p with L <= p < H (and p < 0xE) belongs to the data region and uses the data base. The region is empty when L >= H, which includes L = H and L = 0xF.
- R5: Pages below both L and H belong to the root region and use the root base, which resets to zero. If L = 0 the root region is empty.
- R6: The frame sum base + page is taken modulo 256, so the physical address wraps within 20 bits.
- R7: `phys_addr[11:0]` always equals the logical address bits 11:0 presented one cycle earlier.
- R8: When `dspace` = 1, inversion register bit 0 flips physical bit 16 and bit 1 flips bit 19 for root-region accesses. Bit 2 flips bit 16 and bit 3 flips bit 19 for data-region accesses. The flip is applied after the base addition.
- R9: When `dspace` = 0, and for stack and extended-code accesses in either space, no bit is flipped. Such a translation does not depend on `dspace`.
- R10: `phys_addr` is registered one cycle after the logical address. A register write strobed in cycle n affects translations of addresses presented in cycle n+1 onward, not the one presented in cycle n.
- R11: Configuration addresses are: 0 size, 1 root base, 2 data base, 3 stack base, 4 extended-code base, 5 inversion (bits 3:0). `cfg_rdata` gives, one cycle later, the value held at `cfg_addr` before any write in that cycle. Inversion bits 7:4 read zero. Addresses 6 and 7 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| log_addr | input | 16 | Logical address |
| dspace | input | 1 | 1 = data-space access, 0 = instruction-space access |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address (read and write) |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Registered read-back of the register at `cfg_addr` |
| phys_addr | output | 20 | Registered 20-bit physical address |

## Verification
A corrupted base register shows at the ports on the very next translation in its region, as a wrong `phys_addr[19:12]`. A wrong boundary nibble shows up as pages attributed to the neighbouring region, and it is only visible on pages near the boundary whose bases differ. A stuck inversion bit appears only on data-space accesses to root or data pages, one cycle after the address. The random mix therefore sweeps every page under random boundaries, bases and space flags. Directed cases pin the empty-region limits, the wrap, and the cycle a write begins to matter.

// File: rtl/amx_pkg.sv
package amx_pkg;
  typedef enum logic [1:0] {
    SEG_ROOT  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_XCODE = 2'd3
  } seg_e;

  localparam int NUM_SEG = 4;
  localparam int CFG_AW  = 3;
  localparam int INV_W   = 4;

  localparam logic [CFG_AW-1:0] CA_SIZE = 3'd0;
  localparam logic [CFG_AW-1:0] CA_BASE0 = 3'd1;
  localparam logic [CFG_AW-1:0] CA_INV  = 3'd5;
endpackage

// File: rtl/amx_cfg_regs.sv
module amx_cfg_regs
  import amx_pkg::*;
#(
  parameter int BASE_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             we,
  input  logic [CFG_AW-1:0]                addr,
  input  logic [BASE_W-1:0]                wdata,
  output logic [BASE_W-1:0]                rdata,
  output logic [PAGE_W-1:0]                hi,
  output logic [PAGE_W-1:0]                lo,
  output logic [NUM_SEG-1:0][BASE_W-1:0]   base,
  output logic [INV_W-1:0]                 inv
);
  localparam int SIZE_W = 2 * PAGE_W;

  logic [SIZE_W-1:0] size_q;
  logic [BASE_W-1:0] rd_d;

  assign hi = size_q[SIZE_W-1:PAGE_W];
  assign lo = size_q[PAGE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q <= '0;
      inv    <= '0;
    end else if (we) begin
      if (addr == CA_SIZE) size_q <= wdata[SIZE_W-1:0];
      if (addr == CA_INV)  inv    <= wdata[INV_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_base
    localparam logic [CFG_AW-1:0] MY_ADDR = CFG_AW'(int'(CA_BASE0) + g);
    always_ff @(posedge clk) begin
      if (rst)                          base[g] <= '0;
      else if (we && addr == MY_ADDR)   base[g] <= wdata;
    end
  end

  always_comb begin
    rd_d = '0;
    if (addr == CA_SIZE)      rd_d = BASE_W'(size_q);
    else if (addr == CA_INV)  rd_d = BASE_W'(inv);
    else if (addr >= CA_BASE0 && addr < CFG_AW'(int'(CA_BASE0) + NUM_SEG))
      rd_d = base[addr - CA_BASE0];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_d;
  end
endmodule

// File: rtl/amx_seg_sel.sv
module amx_seg_sel
  import amx_pkg::*;
#(
  parameter int PAGE_W = 4
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [PAGE_W-1:0] hi,
  input  logic [PAGE_W-1:0] lo,
  output seg_e              seg
);
  // the window covers the top two pages of the logical space
  localparam logic [PAGE_W-1:0] XC_FIRST = PAGE_W'((1 << PAGE_W) - 2);

  always_comb begin
    if (page >= XC_FIRST)  seg = SEG_XCODE;
    else if (page >= hi)   seg = SEG_STACK;
    else if (page >= lo)   seg = SEG_DATA;
    else                   seg = SEG_ROOT;
  end
endmodule

// File: rtl/amx_phys_map.sv
module amx_phys_map
  import amx_pkg::*;
#(
  parameter int BASE_W  = 8,
  parameter int PAGE_W  = 4,
  parameter int OFF_W   = 12,
  parameter int LO_FLIP = 16
) (
  input  logic [BASE_W-1:0]       base,
  input  logic [PAGE_W-1:0]       page,
  input  logic [OFF_W-1:0]        off,
  input  seg_e                    seg,
  input  logic                    dspace,
  input  logic [INV_W-1:0]        inv,
  output logic [BASE_W+OFF_W-1:0] phys
);
  localparam int PA_W = BASE_W + OFF_W;

  logic [BASE_W-1:0] frame;
  logic              flip_lo;
  logic              flip_hi;
  logic [PA_W-1:0]   mask;

  assign frame = base + BASE_W'(page);

  always_comb begin
    flip_lo = 1'b0;
    flip_hi = 1'b0;
    if (dspace) begin
      unique case (seg)
        SEG_ROOT: begin flip_lo = inv[0]; flip_hi = inv[1]; end
        SEG_DATA: begin flip_lo = inv[2]; flip_hi = inv[3]; end
        default:  ;
      endcase
    end
    mask          = '0;
    mask[LO_FLIP] = flip_lo;
    mask[PA_W-1]  = flip_hi;
  end

  assign phys = {frame, off} ^ mask;
endmodule

// File: rtl/amx_top.sv
module amx_top
  import amx_pkg::*;
#(
  parameter int LA_W   = 16,
  parameter int PAGE_W = 4,
  parameter int BASE_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [LA_W-1:0]             log_addr,
  input  logic                        dspace,
  input  logic                        cfg_we,
  input  logic [CFG_AW-1:0]           cfg_addr,
  input  logic [BASE_W-1:0]           cfg_wdata,
  output logic [BASE_W-1:0]           cfg_rdata,
  output logic [BASE_W+LA_W-PAGE_W-1:0] phys_addr
);
  localparam int OFF_W = LA_W - PAGE_W;
  localparam int PA_W  = BASE_W + OFF_W;

  logic [PAGE_W-1:0]              hi, lo;
  logic [NUM_SEG-1:0][BASE_W-1:0] base_v;
  logic [INV_W-1:0]               inv;
  seg_e                           seg;
  logic [PA_W-1:0]                phys_d;

  amx_cfg_regs #(.BASE_W(BASE_W), .PAGE_W(PAGE_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .hi(hi), .lo(lo), .base(base_v), .inv(inv)
  );

  amx_seg_sel #(.PAGE_W(PAGE_W)) u_sel (
    .page(log_addr[LA_W-1:OFF_W]), .hi(hi), .lo(lo), .seg(seg)
  );

  amx_phys_map #(.BASE_W(BASE_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W), .LO_FLIP(16)) u_map (
    .base(base_v[seg]), .page(log_addr[LA_W-1:OFF_W]), .off(log_addr[OFF_W-1:0]),
    .seg(seg), .dspace(dspace), .inv(inv), .phys(phys_d)
  );

  always_ff @(posedge clk) begin
    if (rst) phys_addr <= '0;
    else     phys_addr <= phys_d;
  end
endmodule

// File: rtl/amx_chk.sv
module amx_chk #(
  parameter int LA_W   = 16,
  parameter int PAGE_W = 4,
  parameter int BASE_W = 8
) (
  input logic                          clk,
  input logic                          rst,
  input logic [LA_W-1:0]               log_addr,
  input logic                          dspace,
  input logic                          cfg_we,
  input logic [2:0]                    cfg_addr,
  input logic [BASE_W-1:0]             cfg_rdata,
  input logic [BASE_W+LA_W-PAGE_W-1:0] phys_addr
);
  localparam int OFF_W = LA_W - PAGE_W;
  localparam logic [PAGE_W-1:0] XC_FIRST = PAGE_W'((1 << PAGE_W) - 2);

  // R1: reset clears both outputs
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (phys_addr == '0 && cfg_rdata == '0));

  // R7: page offset passes straight through with one cycle of latency
  p_offset_pass_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> phys_addr[OFF_W-1:0] == $past(log_addr[OFF_W-1:0]));

  // R11: unmapped configuration addresses read zero
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg_addr) > 3'd5) |-> cfg_rdata == '0);

  // R11: upper bits of the inversion register read zero
  p_inv_upper_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg_addr) == 3'd5) |-> cfg_rdata[BASE_W-1:4] == '0);

  // R9: an extended-code page translates the same whatever the space flag
  p_xcode_space_free_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(log_addr[LA_W-1:OFF_W]) >= XC_FIRST &&
     $past(log_addr) == $past(log_addr, 2) && !$past(cfg_we, 2) &&
     $past(dspace) != $past(dspace, 2))
    |-> phys_addr == $past(phys_addr));
endmodule

bind amx_top amx_chk #(.LA_W(LA_W), .PAGE_W(PAGE_W), .BASE_W(BASE_W)) u_chk (
  .clk(clk), .rst(rst), .log_addr(log_addr), .dspace(dspace), .cfg_we(cfg_we),
  .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata), .phys_addr(phys_addr)
);

// File: tb/sim_amx_top.sv
`timescale 1ns/1ps
module sim_amx_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] log_addr = '0;
  logic        dspace = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [19:0] phys_addr;

  int total = 0;
  int bad   = 0;
  string force_tag = "";

  // bench model of the configuration
  logic [7:0] m_size, m_root, m_data, m_stack, m_xc;
  logic [3:0] m_inv;

  always #2 clk = ~clk;

  amx_top u0 (
    .clk(clk), .rst(rst), .log_addr(log_addr), .dspace(dspace), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .phys_addr(phys_addr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int region(input logic [15:0] la);
    logic [3:0] p;
    p = la[15:12];
    if (p >= 4'hE)            return 3;
    else if (p >= m_size[7:4]) return 2;
    else if (p >= m_size[3:0]) return 1;
    else                       return 0;
  endfunction

  function automatic logic [19:0] model(input logic [15:0] la, input logic dsp);
    int r;
    logic [7:0] b, f;
    logic [19:0] v;
    r = region(la);
    case (r)
      0: b = m_root;
      1: b = m_data;
      2: b = m_stack;
      default: b = m_xc;
    endcase
    f = b + {4'h0, la[15:12]};
    v = {f, la[11:0]};
    if (dsp && r == 0) begin v[16] ^= m_inv[0]; v[19] ^= m_inv[1]; end
    if (dsp && r == 1) begin v[16] ^= m_inv[2]; v[19] ^= m_inv[3]; end
    return v;
  endfunction

  function automatic logic [7:0] rd_model(input logic [2:0] a);
    case (a)
      3'd0: return m_size;
      3'd1: return m_root;
      3'd2: return m_data;
      3'd3: return m_stack;
      3'd4: return m_xc;
      3'd5: return {4'h0, m_inv};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [15:0] la, input logic dsp);
    int r;
    logic [8:0] s;
    r = region(la);
    s = {1'b0, (r == 0) ? m_root : (r == 1) ? m_data : (r == 2) ? m_stack : m_xc} + {5'h0, la[15:12]};
    if (force_tag != "") return force_tag;
    if (s[8]) return "R6";
    if (dsp && r <= 1 && m_inv != 0) return "R8";
    if (!dsp && r <= 1 && m_inv != 0) return "R9";
    case (r)
      0: return "R5";
      1: return "R4";
      2: return "R3";
      default: return "R2";
    endcase
  endfunction

  // one cycle: drive at a falling edge, check at the next falling edge
  task automatic step(input logic [15:0] la, input logic dsp, input logic we,
                      input logic [2:0] a, input logic [7:0] d);
    logic [19:0] ep;
    logic [7:0]  er;
    string t;
    ep = model(la, dsp);
    er = rd_model(a);
    t  = tag_of(la, dsp);
    log_addr = la; dspace = dsp; cfg_we = we; cfg_addr = a; cfg_wdata = d;
    if (we) begin
      case (a)
        3'd0: m_size  = d;
        3'd1: m_root  = d;
        3'd2: m_data  = d;
        3'd3: m_stack = d;
        3'd4: m_xc    = d;
        3'd5: m_inv   = d[3:0];
        default: ;
      endcase
    end
    @(negedge clk);
    cfg_we = 1'b0;
    chk(phys_addr == ep, t, 32'(phys_addr), 32'(ep));
    chk(phys_addr[11:0] == la[11:0], "R7", 32'(phys_addr[11:0]), 32'(la[11:0]));
    chk(cfg_rdata == er, "R11", 32'(cfg_rdata), 32'(er));
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    step(16'h0000, 1'b0, 1'b1, a, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_size = 0; m_root = 0; m_data = 0; m_stack = 0; m_xc = 0; m_inv = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk(phys_addr == 20'h0, "R1", 32'(phys_addr), 32'h0);
    chk(cfg_rdata == 8'h0, "R1", 32'(cfg_rdata), 32'h0);
    rst = 1'b0;
    force_tag = "R1";
    step(16'h1234, 1'b1, 1'b0, 3'd5, 8'h00);
    step(16'hDFFF, 1'b0, 1'b0, 3'd0, 8'h00);
    force_tag = "";

    // boundaries hi=8 lo=4 and distinct bases
    wr(3'd0, 8'h84); wr(3'd1, 8'h10); wr(3'd2, 8'h20); wr(3'd3, 8'h30); wr(3'd4, 8'hFF);
    step(16'h2ABC, 1'b1, 1'b0, 3'd1, 8'h00);  // R5 root -> 12ABC
    step(16'h3FFF, 1'b0, 1'b0, 3'd2, 8'h00);  // R5 last root page
    step(16'h4000, 1'b1, 1'b0, 3'd3, 8'h00);  // R4 first data page
    step(16'h7123, 1'b0, 1'b0, 3'd4, 8'h00);  // R4 last data page
    step(16'h8000, 1'b1, 1'b0, 3'd0, 8'h00);  // R3 first stack page
    step(16'hDFFF, 1'b1, 1'b0, 3'd0, 8'h00);  // R3 last stack page
    step(16'hE000, 1'b0, 1'b0, 3'd0, 8'h00);  // R2/R6 FF+E wraps
    step(16'hF123, 1'b1, 1'b0, 3'd0, 8'h00);  // R2/R6

    // R8 / R9 inversion, each bit alone and all together
    for (int k = 0; k < 5; k++) begin
      wr(3'd5, (k == 4) ? 8'hFF : 8'(1 << k));
      step(16'h2ABC, 1'b1, 1'b0, 3'd5, 8'h00);
      step(16'h5ABC, 1'b1, 1'b0, 3'd5, 8'h00);
      step(16'h2ABC, 1'b0, 1'b0, 3'd5, 8'h00);
      step(16'h5ABC, 1'b0, 1'b0, 3'd5, 8'h00);
      step(16'h9ABC, 1'b1, 1'b0, 3'd5, 8'h00);
      step(16'hEABC, 1'b1, 1'b0, 3'd5, 8'h00);
    end

    // empty-region limits: R3 R4 R5
    wr(3'd0, 8'h00); step(16'h0100, 1'b1, 1'b0, 3'd0, 8'h00); step(16'hD100, 1'b1, 1'b0, 3'd0, 8'h00);
    wr(3'd0, 8'h40); step(16'h0100, 1'b1, 1'b0, 3'd0, 8'h00); step(16'h3100, 1'b1, 1'b0, 3'd0, 8'h00);
    wr(3'd0, 8'h55); step(16'h4100, 1'b1, 1'b0, 3'd0, 8'h00); step(16'h5100, 1'b1, 1'b0, 3'd0, 8'h00);
    wr(3'd0, 8'hF3); step(16'hD100, 1'b1, 1'b0, 3'd0, 8'h00); step(16'h2100, 1'b1, 1'b0, 3'd0, 8'h00);
    wr(3'd0, 8'hEF); step(16'hD100, 1'b1, 1'b0, 3'd0, 8'h00);
    wr(3'd0, 8'hE3); step(16'hD100, 1'b1, 1'b0, 3'd0, 8'h00);

    // R10: the write's own cycle still sees the old base
    force_tag = "R10";
    step(16'hE000, 1'b0, 1'b1, 3'd4, 8'h40);
    step(16'hE000, 1'b0, 1'b0, 3'd4, 8'h00);
    step(16'hE000, 1'b1, 1'b1, 3'd4, 8'h41);
    step(16'hE000, 1'b1, 1'b0, 3'd4, 8'h00);
    force_tag = "";

    // R11: writes to unused addresses change nothing; read everything back
    wr(3'd6, 8'hAA); wr(3'd7, 8'h55);
    for (int a = 0; a < 8; a++) step(16'h6000, 1'b1, 1'b0, 3'(a), 8'h00);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic we;
      we = ($urandom % 6) == 0;
      step(16'($urandom), 1'($urandom), we, 3'($urandom), 8'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule